// File: doc/BRIEF.md
# Microcontroller External Bus Glue

This block sits between an 8-bit microcontroller with a multiplexed external bus and a single 32 KB SRAM. On one 8-bit port the processor sends the low address byte and then the data byte. The block holds that low byte when the address-latch enable drops. It joins the held byte with the high address port to form a 16-bit memory address. It also produces the SRAM chip select, output enable and write enable.

Program fetches and data reads both enable the same SRAM, so code and variables share one device. Code starts at 0x0000 and data starts at 0x5000.

One external-data address, 0x7F55, is also decoded as a seven-segment display port. A write to that address loads the low seven data bits into a display register. Because the address lies inside the SRAM window, the SRAM location is written as well. The display register cannot be read back: reads of that address return SRAM data.

Top module: `mcu_bus_glue`

## Requirements
- R1: While `ale` is high, `mem_addr[7:0]` follows `ad_bus`. From the first clock edge that samples `ale` low, `mem_addr[7:0]` holds the value of `ad_bus` sampled at the last edge that saw `ale` high.
- R2: `mem_addr[15:8]` always equals `addr_hi`, with no delay.
- R3: `mem_cs_n` is low exactly when `mem_addr[15]` is 0, which is the range 0x0000 to 0x7FFF. An access at 0x8000 or above never touches the SRAM.
- R4: `mem_oe_n` is low exactly when `mem_cs_n` is low and either `psen_n` or `rd_n` is low (both strobes are active-low).
- R5: `mem_we_n` is low exactly when `mem_cs_n` is low and `wr_n` is low.
- R6: The display register loads at the first clock edge that samples `wr_n` high after it was low, and only if all 16 bits of `mem_addr` equal 0x7F55. The value loaded is bits 6..0 of the last byte on `ad_bus` while `wr_n` was low. `seg_out[0]` is segment a and `seg_out[6]` is segment g. Data bit 7 is dropped.
- R7: Writes to any other address, such as 0x7F54 or 0xFF55, leave `seg_out` unchanged.
- R8: Reads and fetches at 0x7F55 leave `seg_out` unchanged.
- R9: While `rst_n` is low, `seg_out` is 0 (all segments off) and the held low address byte is 0.
- R10: A write to 0x7F55 also drives `mem_we_n` low at address 0x7F55, so the SRAM stores the same byte.
- R11: Writing 0x00 to 0x7F55 turns off all segments, and the value stays until the next write to 0x7F55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the bus strobes |
| rst_n | input | 1 | Active-low reset |
| ale | input | 1 | Address-latch enable from the processor |
| psen_n | input | 1 | Program fetch strobe, active-low |
| rd_n | input | 1 | Data read strobe, active-low |
| wr_n | input | 1 | Data write strobe, active-low |
| ad_bus | input | 8 | Multiplexed low address / data byte |
| addr_hi | input | 8 | High address byte |
| mem_addr | output | 16 | Demultiplexed full address to the SRAM |
| mem_cs_n | output | 1 | SRAM chip select, active-low |
| mem_oe_n | output | 1 | SRAM output enable, active-low |
| mem_we_n | output | 1 | SRAM write enable, active-low |
| seg_out | output | 7 | Segment drive, bit 0 = a through bit 6 = g |

## Verification
The address high byte and the three SRAM controls are combinational, so they are due in the same cycle as the inputs that cause them. The held low byte takes effect from the first clock edge that samples `ale` low. The display value is due after the first edge that samples `wr_n` high, so it can first be seen at the next falling clock edge.

The bench drives inputs 2 ns after each rising edge and compares at each falling edge. Its reference state advances only on rising edges, so every comparison already accounts for the one-edge delays. Directed checks confirm that a display write reached both the register and the modelled SRAM. They also confirm that stores to neighbouring addresses, stores outside the SRAM window and reads of the port leave the display unchanged.

// File: rtl/busglue_pkg.sv
package busglue_pkg;
  localparam int unsigned LO_W      = 8;
  localparam int unsigned HI_W      = 8;
  localparam int unsigned ADDR_W    = LO_W + HI_W;
  localparam int unsigned MEM_BYTES = 32768;
  localparam int unsigned MEM_AW    = $clog2(MEM_BYTES);
  localparam int unsigned SEG_W     = 7;

  // SRAM window: every address bit above the SRAM's own span must be zero
  function automatic logic in_sram(input logic [ADDR_W-1:0] a);
    return (a >> MEM_AW) == '0;
  endfunction

  // Full-width compare against the decoded port address
  function automatic logic is_port(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] port);
    return a == port;
  endfunction

  // Memory read is wanted on either a fetch or a data read
  function automatic logic read_wanted(input logic psen_n, input logic rd_n);
    return !psen_n || !rd_n;
  endfunction
endpackage

// File: rtl/busglue_addr_demux.sv
module busglue_addr_demux
  import busglue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   hi_in,
  output logic [ADDR_W-1:0] addr
);
  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_now;

  // Open while the enable is high, frozen at the last sampled byte after it drops
  always_ff @(posedge clk) begin
    if (!rst_n)   lo_q <= '0;
    else if (ale) lo_q <= ad_in;
  end

  assign lo_now = ale ? ad_in : lo_q;
  assign addr   = {hi_in, lo_now};

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> addr[LO_W-1:0] == $past(ad_in)); // R1
  AST_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(addr[LO_W-1:0])); // R1
endmodule

// File: rtl/busglue_mem_strobe.sv
module busglue_mem_strobe
  import busglue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n
);
  logic sel;
  logic rd_req;

  assign sel    = in_sram(addr);
  assign rd_req = read_wanted(psen_n, rd_n);
  assign cs_n   = !sel;
  assign oe_n   = !(sel && rd_req);
  assign we_n   = !(sel && !wr_n);

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !addr[ADDR_W-1]); // R5
  AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!psen_n || !rd_n)); // R4
  AST_CS_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ADDR_W-1] |-> cs_n); // R3
endmodule

// File: rtl/busglue_seg_port.sv
module busglue_seg_port
  import busglue_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h7F55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic [LO_W-1:0]   ad_in,
  output logic [SEG_W-1:0]  seg
);
  logic             wr_q;
  logic [LO_W-1:0]  wd_q;
  logic [SEG_W-1:0] seg_q;
  logic             wr_rise;
  logic             port_hit;

  assign wr_rise  = wr_n && !wr_q;
  assign port_hit = is_port(addr, PORT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      wd_q  <= '0;
      seg_q <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_n)               wd_q  <= ad_in;
      if (wr_rise && port_hit) seg_q <= wd_q[SEG_W-1:0];
    end
  end

  assign seg = seg_q;

  AST_SEG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_q) |-> ($past(wr_n) && !$past(wr_n, 2))); // R6
  AST_SEG_ONLY_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_q) |-> $past(addr) == PORT_ADDR); // R7
endmodule

// File: rtl/mcu_bus_glue.sv
module mcu_bus_glue
  import busglue_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h7F55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [LO_W-1:0]   ad_bus,
  input  logic [HI_W-1:0]   addr_hi,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [SEG_W-1:0]  seg_out
);
  logic [ADDR_W-1:0] full_addr;

  busglue_addr_demux u_demux (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .ad_in (ad_bus),
    .hi_in (addr_hi),
    .addr  (full_addr)
  );

  busglue_mem_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (full_addr),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .cs_n   (mem_cs_n),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n)
  );

  busglue_seg_port #(.PORT_ADDR(PORT_ADDR)) u_seg (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (full_addr),
    .wr_n  (wr_n),
    .ad_in (ad_bus),
    .seg   (seg_out)
  );

  assign mem_addr = full_addr;

  AST_PORT_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && full_addr == PORT_ADDR) |-> !mem_we_n); // R10
  AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[ADDR_W-1:LO_W] == addr_hi); // R2
endmodule

// File: tb/mcu_bus_glue_test.sv
module mcu_bus_glue_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_bus = 8'hFF, addr_hi = 8'h00;
  logic [15:0] mem_addr;
  logic mem_cs_n, mem_oe_n, mem_we_n;
  logic [6:0] seg_out;

  int vectors = 0;
  int errors = 0;
  logic [7:0] sram [int];

  // reference state
  logic [7:0] m_lo = 8'h00;
  logic [7:0] m_wd = 8'h00;
  logic       m_wrq = 1'b1;
  logic [6:0] m_seg = 7'h00;

  always #5 clk = ~clk;

  mcu_bus_glue uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_bus(ad_bus), .addr_hi(addr_hi), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .seg_out(seg_out)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model and SRAM model advance on rising edges
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 8'h00; m_wd = 8'h00; m_wrq = 1'b1; m_seg = 7'h00;
    end else begin
      if (wr_n && !m_wrq && {addr_hi, (ale ? ad_bus : m_lo)} == 16'h7F55)
        m_seg = m_wd[6:0];
      if (!wr_n) m_wd = ad_bus;
      m_wrq = wr_n;
      if (ale) m_lo = ad_bus;
      if (!mem_we_n) sram[int'(mem_addr[14:0])] = ad_bus;
    end
  end

  // Compare at every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] ea;
      ea = {addr_hi, (ale ? ad_bus : m_lo)};
      check("R1 low addr", mem_addr[7:0], ea[7:0]);
      check("R2 high addr", mem_addr[15:8], addr_hi);
      check("R3 cs_n", mem_cs_n, ea[15]);
      check("R4 oe_n", mem_oe_n, (ea[15] || (psen_n && rd_n)) ? 1 : 0);
      check("R5 we_n", mem_we_n, (ea[15] || wr_n) ? 1 : 0);
      check("R6 R7 R8 R11 seg", seg_out, m_seg);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // kind: 0 fetch, 1 read, 2 write
  task automatic bus(input int kind, input logic [15:0] a, input logic [7:0] d);
    addr_hi = a[15:8]; ad_bus = a[7:0]; ale = 1'b1; step();
    ale = 1'b0; step();
    ad_bus = (kind == 2) ? d : 8'hZZ;
    if (kind == 2) ad_bus = d; else ad_bus = 8'h5A;
    if (kind == 0) psen_n = 1'b0;
    if (kind == 1) rd_n = 1'b0;
    if (kind == 2) wr_n = 1'b0;
    step(); step();
    psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; step();
    ad_bus = 8'hFF; step();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R9 during reset
    ale = 1'b1; ad_bus = 8'hC3; step(); ale = 1'b0; ad_bus = 8'hFF;
    step(); step();
    #3;
    check("R9 seg in reset", seg_out, 0);
    check("R9 low addr in reset", mem_addr[7:0], 0);
    rst_n = 1'b1; step();

    bus(0, 16'h0000, 8'h00);              // fetch at code base
    bus(0, 16'h0123, 8'h00);
    bus(2, 16'h5000, 8'h3C);              // data variable
    check("R5 sram data write", sram[int'(16'h5000)], 8'h3C);
    bus(1, 16'h5000, 8'h00);

    // transparency while ale high (R1)
    addr_hi = 8'h12; ale = 1'b1; ad_bus = 8'h77; #1;
    check("R1 transparent", mem_addr, 16'h1277);
    step(); ale = 1'b0; ad_bus = 8'hAA; step();
    check("R1 held", mem_addr, 16'h1277);

    bus(2, 16'h7F55, 8'hB6);              // bit 7 dropped
    check("R6 seg load", seg_out, 7'h36);
    check("R10 shadow sram", sram[int'(16'h7F55)], 8'hB6);

    bus(2, 16'h7F54, 8'h11);
    check("R7 neighbour write", seg_out, 7'h36);
    check("R7 neighbour sram", sram[int'(16'h7F54)], 8'h11);
    bus(2, 16'hFF55, 8'h22);
    check("R7 upper write seg", seg_out, 7'h36);
    check("R3 no alias sram", sram[int'(16'h7F55)], 8'hB6);

    bus(1, 16'h7F55, 8'h00);
    check("R8 read port", seg_out, 7'h36);
    bus(0, 16'h7F55, 8'h00);
    check("R8 fetch port", seg_out, 7'h36);

    bus(2, 16'h7F55, 8'h49);
    check("R6 second load", seg_out, 7'h49);
    bus(2, 16'h7F55, 8'h00);
    check("R11 blank", seg_out, 0);
    bus(1, 16'h0040, 8'h00);
    check("R11 persists", seg_out, 0);
    check("R10 blank shadow", sram[int'(16'h7F55)], 8'h00);

    bus(1, 16'h9000, 8'h00);              // outside window
    bus(2, 16'h7F55, 8'h7F);
    check("R6 all on", seg_out, 7'h7F);

    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule